// File: doc/BRIEF.md
# Adaptive Noise-Floor Energy Detector

This block learns the receiver's background noise level for each of two antennas and raises an energy-detect flag when an incoming signal strength sample is loud enough. Strength samples arrive with a valid strobe, an antenna index and a quiet qualifier. The quiet qualifier is high when the modem sees no phase-modulated carrier. A sample that is valid and quiet, taken while the receiver is enabled, is stored in a circular history of the most recent entries for its antenna. The noise floor of that antenna is the smallest value held in its history.

The floor is refreshed by a sequential scan over the history after each store, and the previous floor is held while the scan runs. A newly stored sample that is below the current floor lowers it on the next clock. This gives a usable estimate right after the first quiet sample. The detect threshold is either a fixed code or the floor of the sample's antenna plus a programmable offset, with the sum clipped at the top code. Turning the receiver off forces the flag low and leaves every learned history and floor in place.

Top module: `nf_energy_det`

## Requirements
- R1: After synchronous reset, `ed_flag` is 0 and every floor reads 255, the top code. A floor stays at 255 until its antenna has stored at least one sample.
- R2: A sample is stored only when `smp_vld`, `smp_quiet` and `rx_en` are all 1 in the same cycle. Other samples leave both floors unchanged.
- R3: Within 2*DEPTH+8 cycles after the last store, each floor equals the minimum of the most recent min(n, DEPTH) samples stored for that antenna, where n is the number stored so far. DEPTH is 256. The DEPTH+1-th store overwrites the oldest entry.
- R4: Antenna 0 and antenna 1, chosen by `smp_ant`, keep separate histories and floors. A store to one antenna never changes the other's floor.
- R5: When a stored sample is below the current floor of its antenna, that floor equals the sample one clock later.
- R6: A floor never rises except on the cycle in which a scan completes. When a store evicts the current minimum, the floor keeps its old value on the following cycle.
- R7: While `rx_en` is 0, `ed_flag` is 0 from the next clock on. Floors and histories are unchanged by toggling `rx_en`.
- R8: With `rel_mode` = 0, each valid sample taken while `rx_en` is 1 sets `ed_flag` on the next clock to (`smp_rssi` > `abs_thr`).
- R9: With `rel_mode` = 1, the threshold is min(255, floor[`smp_ant`] + `rel_off`). The floor used is its value before that sample's clock. The comparison is strictly greater, so a floor of 255 keeps the flag at 0.
- R10: In cycles with `rx_en` = 1 and `smp_vld` = 0, `ed_flag` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Strength sample valid |
| smp_rssi | input | 8 | Strength code, 1 dB per step |
| smp_ant | input | 1 | Antenna index of the sample |
| smp_quiet | input | 1 | No modulated carrier present; allows storing |
| rx_en | input | 1 | Receiver enable |
| rel_mode | input | 1 | 1: threshold relative to the floor; 0: fixed threshold |
| abs_thr | input | 8 | Fixed threshold code |
| rel_off | input | 8 | Offset above the floor, in dB |
| ed_flag | output | 1 | Energy-detect result |
| floor_all | output | 16 | Floors; bits 7:0 belong to antenna 0, bits 15:8 to antenna 1 |

## Verification
Two things can happen to the same antenna in one cycle: a new store, and the completion of the scan started by an earlier store. In that cycle the published floor must fold in the new sample and then rescan. Random bursts of back-to-back quiet samples on both antennas create this overlap often. After each burst the bench idles past the rescan bound and compares both floors with a model of the most recent samples. A second overlap is a relative-mode decision taken on the very clock where the floor changes. The bench judges it against the floor read from the port just before that edge.

// File: rtl/nf_pkg.sv
package nf_pkg;

    localparam int NF_RSSI_W = 8;

    typedef logic [NF_RSSI_W-1:0] rssi_t;

    localparam rssi_t NF_RSSI_MAX = '1;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_RUN  = 1'b1
    } scan_st_e;

    typedef struct packed {
        logic  rel;
        rssi_t abs_thr;
        rssi_t off;
    } thr_cfg_t;

    function automatic rssi_t rssi_min(input rssi_t a, input rssi_t b);
        return (a < b) ? a : b;
    endfunction

    function automatic rssi_t rssi_sat_add(input rssi_t a, input rssi_t b);
        logic [NF_RSSI_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[NF_RSSI_W] ? NF_RSSI_MAX : s[NF_RSSI_W-1:0];
    endfunction

endpackage

// File: rtl/nf_hist_bank.sv
module nf_hist_bank
    import nf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  rssi_t wr_code,
    output rssi_t floor_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0]   FULL = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    rssi_t          mem [DEPTH];
    logic [AW-1:0]  wptr;
    logic [AW:0]    fill;
    scan_st_e       st;
    logic [AW-1:0]  sidx;
    rssi_t          acc;
    logic           pend;
    rssi_t          floor_q;

    rssi_t acc_step;
    logic  rd_ok;
    logic  done;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_code;
    end

    always_comb begin
        rd_ok    = (fill == FULL) || ({1'b0, sidx} < fill);
        acc_step = acc;
        if (rd_ok) acc_step = rssi_min(acc_step, mem[sidx]);
        if (wr_en) acc_step = rssi_min(acc_step, wr_code);
        done     = (st == SC_RUN) && (sidx == LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr    <= '0;
            fill    <= '0;
            st      <= SC_IDLE;
            sidx    <= '0;
            acc     <= NF_RSSI_MAX;
            pend    <= 1'b0;
            floor_q <= NF_RSSI_MAX;
        end else begin
            if (wr_en) begin
                wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
                if (fill != FULL) fill <= fill + 1'b1;
                if (!done && wr_code < floor_q) floor_q <= wr_code;
            end
            unique case (st)
                SC_IDLE: begin
                    if (wr_en) begin
                        st   <= SC_RUN;
                        sidx <= '0;
                        acc  <= NF_RSSI_MAX;
                        pend <= 1'b0;
                    end
                end
                SC_RUN: begin
                    if (done) begin
                        floor_q <= acc_step;
                        sidx    <= '0;
                        acc     <= NF_RSSI_MAX;
                        pend    <= 1'b0;
                        if (!(wr_en || pend)) st <= SC_IDLE;
                    end else begin
                        sidx <= sidx + 1'b1;
                        acc  <= acc_step;
                        if (wr_en) pend <= 1'b1;
                    end
                end
                default: st <= SC_IDLE;
            endcase
        end
    end

    assign floor_o = floor_q;

    // R1: an empty history reads as the top code
    p_empty_top_r1: assert property (@(posedge clk) disable iff (rst)
        (fill == '0) |-> (floor_q == NF_RSSI_MAX));

    // R2: history pointers move only on a store
    p_no_store_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(fill) && $stable(wptr)));

    // R5: after a store the floor is no higher than the stored code
    p_fast_lower_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (floor_q <= $past(wr_code)));

    // R6: the floor can rise only when a scan completes
    p_rise_on_done_r6: assert property (@(posedge clk) disable iff (rst)
        !done |=> (floor_q <= $past(floor_q)));

endmodule

// File: rtl/nf_thresh_cmp.sv
module nf_thresh_cmp
    import nf_pkg::*;
(
    input  rssi_t    rssi,
    input  rssi_t    floor_in,
    input  thr_cfg_t cfg,
    output logic     exceed
);
    rssi_t thr;

    always_comb begin
        thr    = cfg.rel ? rssi_sat_add(floor_in, cfg.off) : cfg.abs_thr;
        exceed = (rssi > thr);
    end

endmodule

// File: rtl/nf_energy_det.sv
module nf_energy_det
    import nf_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int NANT  = 2,
    parameter int ANT_W = (NANT > 1) ? $clog2(NANT) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_vld,
    input  logic [NF_RSSI_W-1:0]      smp_rssi,
    input  logic [ANT_W-1:0]          smp_ant,
    input  logic                      smp_quiet,
    input  logic                      rx_en,
    input  logic                      rel_mode,
    input  logic [NF_RSSI_W-1:0]      abs_thr,
    input  logic [NF_RSSI_W-1:0]      rel_off,
    output logic                      ed_flag,
    output logic [NANT*NF_RSSI_W-1:0] floor_all
);
    rssi_t    floors [NANT];
    rssi_t    sel_floor;
    thr_cfg_t cfg;
    logic     exceed;
    logic     ed_q;
    logic     store;

    assign store = smp_vld && smp_quiet && rx_en;

    for (genvar g = 0; g < NANT; g++) begin : g_ant
        logic wr_g;
        assign wr_g = store && (smp_ant == ANT_W'(g));

        nf_hist_bank #(.DEPTH(DEPTH)) i_bank (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_g),
            .wr_code (smp_rssi),
            .floor_o (floors[g])
        );

        assign floor_all[g*NF_RSSI_W +: NF_RSSI_W] = floors[g];
    end

    always_comb begin
        sel_floor = NF_RSSI_MAX;
        for (int i = 0; i < NANT; i++) begin
            if (smp_ant == ANT_W'(i)) sel_floor = floors[i];
        end
        cfg = '{rel: rel_mode, abs_thr: abs_thr, off: rel_off};
    end

    nf_thresh_cmp i_cmp (
        .rssi     (smp_rssi),
        .floor_in (sel_floor),
        .cfg      (cfg),
        .exceed   (exceed)
    );

    always_ff @(posedge clk) begin
        if (rst)          ed_q <= 1'b0;
        else if (!rx_en)  ed_q <= 1'b0;
        else if (smp_vld) ed_q <= exceed;
    end

    assign ed_flag = ed_q;

    // R7: receiver off drives the flag low
    p_ed_off_r7: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !ed_flag);

    // R10: no sample, no change of the flag
    p_ed_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !smp_vld) |=> $stable(ed_flag));

endmodule

// File: tb/test_nf_energy_det.sv
module test_nf_energy_det;

    localparam int DEPTH = 256;
    localparam int SETTLE = 2 * DEPTH + 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_vld;
    logic [7:0]  smp_rssi;
    logic [0:0]  smp_ant;
    logic        smp_quiet;
    logic        rx_en;
    logic        rel_mode;
    logic [7:0]  abs_thr;
    logic [7:0]  rel_off;
    logic        ed_flag;
    logic [15:0] floor_all;

    nf_energy_det #(.DEPTH(DEPTH), .NANT(2)) i_nf_energy_det (
        .clk       (clk),
        .rst       (rst),
        .smp_vld   (smp_vld),
        .smp_rssi  (smp_rssi),
        .smp_ant   (smp_ant),
        .smp_quiet (smp_quiet),
        .rx_en     (rx_en),
        .rel_mode  (rel_mode),
        .abs_thr   (abs_thr),
        .rel_off   (rel_off),
        .ed_flag   (ed_flag),
        .floor_all (floor_all)
    );

    always #4 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    int mdl [2][DEPTH];
    int mptr [2];
    int mcnt [2];
    bit ed_exp = 0;

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int flr(input int a);
        return (a == 0) ? int'(floor_all[7:0]) : int'(floor_all[15:8]);
    endfunction

    function automatic int mdl_min(input int a);
        int m = 255;
        int n = (mcnt[a] < DEPTH) ? mcnt[a] : DEPTH;
        for (int i = 0; i < n; i++) if (mdl[a][i] < m) m = mdl[a][i];
        return m;
    endfunction

    // Called at a negedge: apply inputs, advance one clock, check the flag.
    task automatic cyc(input bit v, input int r, input int a, input bit q);
        int thr;
        smp_vld = v; smp_rssi = 8'(r); smp_ant = 1'(a); smp_quiet = q;
        if (!rx_en) ed_exp = 0;
        else if (v) begin
            thr = rel_mode ? flr(a) + int'(rel_off) : int'(abs_thr);
            if (thr > 255) thr = 255;
            ed_exp = (r > thr);
        end
        @(negedge clk);
        if (v && q && rx_en) begin
            mdl[a][mptr[a]] = r;
            mptr[a] = (mptr[a] + 1) % DEPTH;
            mcnt[a]++;
        end
        if (!rx_en)         chk(ed_flag, ed_exp, "R7 flag off");
        else if (!v)        chk(ed_flag, ed_exp, "R10 flag hold");
        else if (rel_mode)  chk(ed_flag, ed_exp, "R9 relative flag");
        else                chk(ed_flag, ed_exp, "R8 absolute flag");
    endtask

    task automatic settle();
        for (int i = 0; i < SETTLE; i++) cyc(0, 0, 0, 0);
        chk(flr(0), mdl_min(0), "R3 floor ant0");
        chk(flr(1), mdl_min(1), "R3 floor ant1");
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int keep0;
        void'($urandom(32'd4711));
        for (int a = 0; a < 2; a++) begin mptr[a] = 0; mcnt[a] = 0; end
        rst = 1; smp_vld = 0; smp_rssi = 0; smp_ant = 0; smp_quiet = 0;
        rx_en = 0; rel_mode = 0; abs_thr = 8'd80; rel_off = 8'd0;
        repeat (4) @(negedge clk);
        chk(ed_flag, 0, "R1 reset flag");
        chk(flr(0), 255, "R1 reset floor ant0");
        chk(flr(1), 255, "R1 reset floor ant1");
        rst = 0; rx_en = 1;

        // R9: empty floor blocks relative detection
        rel_mode = 1; rel_off = 0;
        cyc(1, 255, 0, 0);
        chk(ed_flag, 0, "R9 top floor keeps flag low");

        // R2: non-qualifying samples are not stored
        cyc(1, 10, 0, 0);
        cyc(0, 11, 1, 1);
        rx_en = 0; cyc(1, 12, 0, 1); rx_en = 1;
        settle();
        chk(flr(0), 255, "R2 ignored ant0");
        chk(flr(1), 255, "R2 ignored ant1");

        // R5: fast lowering
        cyc(1, 100, 0, 1);
        chk(flr(0), 100, "R5 first store");
        cyc(1, 40, 0, 1);
        chk(flr(0), 40, "R5 lower store");
        settle();
        chk(flr(1), 255, "R4 other antenna untouched");
        cyc(1, 70, 1, 1);
        settle();
        chk(flr(0), 40, "R4 ant0 kept");
        chk(flr(1), 70, "R4 ant1 own floor");

        // R7: receiver off keeps floors
        rx_en = 0;
        repeat (5) cyc(1, 200, 0, 1);
        chk(ed_flag, 0, "R7 flag low when off");
        rx_en = 1;
        cyc(0, 0, 0, 0);
        chk(flr(0), 40, "R7 ant0 retained");
        chk(flr(1), 70, "R7 ant1 retained");

        // R9: relative threshold with saturation
        rel_mode = 1; rel_off = 8'd250;
        cyc(1, 255, 0, 0);
        chk(ed_flag, 0, "R9 saturated threshold");
        rel_off = 8'd10;
        cyc(1, 51, 0, 0);
        chk(ed_flag, 1, "R9 above floor+off");
        cyc(1, 50, 0, 0);
        chk(ed_flag, 0, "R9 equal floor+off");
        cyc(1, 81, 0, 0);
        cyc(0, 0, 0, 0);
        chk(ed_flag, 1, "R10 hold after sample");

        // R8: absolute threshold
        rel_mode = 0; abs_thr = 8'd80;
        cyc(1, 81, 1, 0);
        chk(ed_flag, 1, "R8 above");
        cyc(1, 80, 1, 0);
        chk(ed_flag, 0, "R8 equal");

        // R6 and R3: eviction of the minimum on antenna 0
        while (mptr[0] != 0) cyc(1, 200, 0, 1);
        cyc(1, 5, 0, 1);
        for (int i = 1; i < DEPTH; i++) cyc(1, 60 + int'($urandom_range(0, 140)), 0, 1);
        settle();
        chk(flr(0), 5, "R3 full window minimum");
        keep0 = flr(0);
        cyc(1, 90, 0, 1);
        chk(flr(0), keep0, "R6 held after evicting minimum");
        settle();

        // Random bursts
        for (int r = 0; r < 30; r++) begin
            rel_mode = 1'($urandom_range(0, 1));
            abs_thr = 8'($urandom_range(0, 255));
            rel_off = 8'($urandom_range(0, 40));
            for (int k = 0; k < int'($urandom_range(20, 150)); k++) begin
                rx_en = ($urandom_range(0, 9) != 0);
                cyc(1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0));
            end
            rx_en = 1;
            settle();
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule